// File: doc/BRIEF.md
# Colour LCD Controller Register File

This block is the software-visible register window of a simple colour LCD controller. It decodes a 4 KB, word-addressed slave window on a 32-bit peripheral bus. Behind that window it holds four panel timing words, the frame-base addresses of the upper and lower panel halves, a control word, an interrupt mask and a raw interrupt status. From these it drives the panel geometry, the pixel-format controls and a single display-enable signal to the pixel pipeline. The pixel pipeline, its fetch engine and the panel timing generator sit outside this block.

A 128-word colour palette window is decoded here, but the storage lives in a neighbouring block. The register file forwards the select, the write strobe, the word index and the write data, and returns the neighbour's read data. The top of the window holds eight read-only identification words. A parameter picks one of two variants. The variants differ in their identification bytes and in whether the control and mask words swap word offsets.

A small state machine follows the committed display-enable state. It has two states: `PANEL_OFF` and `PANEL_ON`. The `POWER_UP` transition (`PANEL_OFF` to `PANEL_ON`) happens on the clock after enable becomes true. The `POWER_DOWN` transition (`PANEL_ON` to `PANEL_OFF`) happens on the clock after enable becomes false. In every other case the state holds. The machine and two stored copies of the geometry are compared with the live values to produce `geometry_changed_o`.

Top module: `lcdreg_top`

## Requirements
- R1: After reset the following hold: every register reads zero; `active_cols_o` is 16 and `active_rows_o` is 1; `enable_o`, `bus_err_o`, `geometry_changed_o` and `bus_rdata_o` are all 0.
- R2: `active_cols_o` equals (timing word 0 bits [7:2] + 1) * 16. Timing word 0 is at byte 0x00. Its other bits have no effect on the column count.
- R3: `active_rows_o` equals timing word 1 bits [9:0] + 1. Timing word 1 is at byte 0x04. Its other bits have no effect on the row count.
- R4: Control word bits drive these outputs:
  - `enable_o` is 1 only when bit 0 and bit 11 are both 1.
  - `bpp_mode_o` is bits [3:1].
  - `bgr_o` is bit 8.
  - `be_byte_o` is bit 9.
  - `be_pix_o` is bit 10.
- R5: A read returns its data on `bus_rdata_o` on the clock after the request. `bus_rdata_o` holds its value between reads. All 32 bits written to these words read back:
  - timing words 0 to 3 at 0x00, 0x04, 0x08 and 0x0C;
  - the upper frame base at 0x10;
  - the lower frame base at 0x14.
  The control word is at 0x18 and the mask at 0x1C when EXTENDED=0; the two swap when EXTENDED=1. The mask keeps bits [4:0] only.
- R6: Raw status reads at 0x20. Each bit is set by a 1 on the matching `irq_evt_i` bit. Masked status reads at 0x24 and equals raw AND mask.
- R7: Writing to 0x28 clears each raw status bit whose data bit is 1. An event on the same clock wins over the clear.
- R8: Bytes 0xFE0 to 0xFFC read one identification byte per word, zero-extended. The bytes, in address order, are:
  - EXTENDED=0: 10,11,04,00,0D,F0,05,B1 (hex).
  - EXTENDED=1: 11,11,24,00,0D,F0,05,B1 (hex).
- R9: An access in bytes 0x200 to 0x3FF drives these outputs in the same cycle:
  - `pal_sel_o`;
  - `pal_we_o`, equal to `bus_we_i`;
  - `pal_index_o`, equal to (address - 0x200) >> 2;
  - `pal_wdata_o`, equal to `bus_wdata_i`.
  A read there returns `pal_rdata_i` as sampled on the request clock.
- R10: Bytes 0x2C and 0x30 read as zero with no error. Writes to them have no effect.
- R11: A read of an undecoded byte returns zero and pulses `bus_err_o` for one cycle. The write-only word 0x28 counts as undecoded for reads. A write to an undecoded byte changes no register and raises no error.
- R12: `geometry_changed_o` is high for exactly the one cycle after a write that changes the column count, the row count or `enable_o`. A write that leaves all three unchanged gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address within the window |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the clock after a read |
| bus_err_o | output | 1 | One-cycle pulse for a read of an undecoded address |
| irq_evt_i | input | IRQ_W | Interrupt event inputs, one per status bit |
| pal_sel_o | output | 1 | Palette window selected |
| pal_we_o | output | 1 | Palette write strobe |
| pal_index_o | output | PAL_IDX_W | Palette word index |
| pal_wdata_o | output | DATA_W | Palette write data |
| pal_rdata_i | input | DATA_W | Palette read data |
| active_cols_o | output | 11 | Decoded active columns |
| active_rows_o | output | 11 | Decoded active rows |
| bpp_mode_o | output | 3 | Pixel depth mode field |
| bgr_o | output | 1 | Swap red and blue |
| be_byte_o | output | 1 | Big-endian byte order |
| be_pix_o | output | 1 | Big-endian pixel order within a byte |
| enable_o | output | 1 | Display enabled |
| geometry_changed_o | output | 1 | One-cycle pulse on a geometry or enable change |

## Verification
Several properties are checked by the assertions on every cycle:
- an error pulse only ever follows a read of an undecoded or write-only word;
- an undecoded write leaves control, mask and timing untouched;
- a status clear removes exactly the written bits unless an event re-sets them;
- events always land in raw status;
- a current-address read returns zero;
- each change pulse has a real cause, and each rise of enable is flagged.

Other behaviour only the bench's scenarios can show:
- the exact scaled column and row values;
- the variant-dependent swap of the control and mask offsets;
- the identification byte sequence;
- the palette round trip through the external store;
- the absence of a pulse when a rewrite leaves the geometry unchanged.

// File: rtl/lcdreg_pkg.sv
package lcdreg_pkg;

    // Register regions produced by the address decoder
    typedef enum logic [3:0] {
        SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_TIM3,
        SEL_UPBASE, SEL_LPBASE, SEL_CTRL, SEL_MASK,
        SEL_RAW, SEL_MASKED, SEL_CLEAR, SEL_CURADDR,
        SEL_PALETTE, SEL_IDENT, SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        PANEL_OFF,
        PANEL_ON
    } panel_state_e;

    // Control word bit positions (decoded by the pixel pipeline)
    localparam int CTL_EN     = 0;
    localparam int CTL_BPP_LO = 1;
    localparam int CTL_BGR    = 8;
    localparam int CTL_BEBYTE = 9;
    localparam int CTL_BEPIX  = 10;
    localparam int CTL_PWR    = 11;

    // Identification byte for word idx of the top-of-window block
    function automatic logic [7:0] ident_byte(input logic ext, input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = ext ? 8'h11 : 8'h10;
            3'd1: b = 8'h11;
            3'd2: b = ext ? 8'h24 : 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdreg_decode.sv
module lcdreg_decode
    import lcdreg_pkg::*;
#(
    parameter bit EXTENDED  = 1'b0,
    parameter int ADDR_W    = 12,
    parameter int PAL_IDX_W = 7
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output reg_sel_e             region_o,
    output logic [PAL_IDX_W-1:0] pal_idx_o,
    output logic [2:0]           id_idx_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] PAL_LO = ADDR_W'('h200);
    localparam logic [ADDR_W-1:0] PAL_HI = ADDR_W'('h400);
    localparam logic [ADDR_W-1:0] ID_LO  = ADDR_W'('hFE0);
    localparam logic [WORD_W-1:0] LAST_REG_WORD = WORD_W'(12);

    logic [WORD_W-1:0] word;

    assign word      = addr_i[ADDR_W-1:2];
    assign pal_idx_o = addr_i[PAL_IDX_W+1:2];
    assign id_idx_o  = addr_i[4:2];

    always_comb begin
        region_o = SEL_NONE;
        if (addr_i >= PAL_LO && addr_i < PAL_HI) begin
            region_o = SEL_PALETTE;
        end else if (addr_i >= ID_LO) begin
            region_o = SEL_IDENT;
        end else if (word <= LAST_REG_WORD) begin
            unique case (word[3:0])
                4'd0:  region_o = SEL_TIM0;
                4'd1:  region_o = SEL_TIM1;
                4'd2:  region_o = SEL_TIM2;
                4'd3:  region_o = SEL_TIM3;
                4'd4:  region_o = SEL_UPBASE;
                4'd5:  region_o = SEL_LPBASE;
                4'd6:  region_o = EXTENDED ? SEL_MASK : SEL_CTRL;
                4'd7:  region_o = EXTENDED ? SEL_CTRL : SEL_MASK;
                4'd8:  region_o = SEL_RAW;
                4'd9:  region_o = SEL_MASKED;
                4'd10: region_o = SEL_CLEAR;
                4'd11: region_o = SEL_CURADDR;
                4'd12: region_o = SEL_CURADDR;
                default: region_o = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcdreg_panel.sv
module lcdreg_panel
    import lcdreg_pkg::*;
#(
    parameter int PPL_W = 6,
    parameter int LPP_W = 10,
    localparam int COL_W = PPL_W + 5,
    localparam int ROW_W = LPP_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PPL_W-1:0] ppl_i,
    input  logic [LPP_W-1:0] lpp_i,
    input  logic             en_bit_i,
    input  logic             pwr_bit_i,
    output logic [COL_W-1:0] cols_o,
    output logic [ROW_W-1:0] rows_o,
    output logic             enable_o,
    output logic             changed_o
);
    localparam logic [COL_W-1:0] COLS_RST = COL_W'(16);
    localparam logic [ROW_W-1:0] ROWS_RST = ROW_W'(1);

    panel_state_e     state_q, state_d;
    logic [COL_W-1:0] cols_prev_q;
    logic [ROW_W-1:0] rows_prev_q;
    logic             en_now;

    // Scaled geometry: columns come in steps of 16, rows are count minus one
    assign cols_o   = {({1'b0, ppl_i} + (PPL_W + 1)'(1)), 4'b0000};
    assign rows_o   = {1'b0, lpp_i} + ROW_W'(1);
    assign en_now   = en_bit_i & pwr_bit_i;
    assign enable_o = en_now;

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= PANEL_OFF;
            cols_prev_q <= COLS_RST;
            rows_prev_q <= ROWS_RST;
        end else begin
            state_q     <= state_d;
            cols_prev_q <= cols_o;
            rows_prev_q <= rows_o;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PANEL_OFF: if (en_now)  state_d = PANEL_ON;   // POWER_UP
            PANEL_ON:  if (!en_now) state_d = PANEL_OFF;  // POWER_DOWN
            default:   state_d = PANEL_OFF;
        endcase
        changed_o = (cols_o != cols_prev_q) || (rows_o != rows_prev_q) ||
                    (en_now != (state_q == PANEL_ON));
    end

    // R12: a pulse always has a cause in the last clock
    a_r12_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        changed_o |-> (cols_o != $past(cols_o) || rows_o != $past(rows_o) ||
                       enable_o != $past(enable_o)));

    // R12: rising enable is always flagged
    a_r12_enable_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(enable_o) |-> changed_o);

endmodule

// File: rtl/lcdreg_top.sv
module lcdreg_top
    import lcdreg_pkg::*;
#(
    parameter bit EXTENDED  = 1'b0,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int IRQ_W     = 5,
    parameter int PAL_IDX_W = 7
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 bus_err_o,
    input  logic [IRQ_W-1:0]     irq_evt_i,
    output logic                 pal_sel_o,
    output logic                 pal_we_o,
    output logic [PAL_IDX_W-1:0] pal_index_o,
    output logic [DATA_W-1:0]    pal_wdata_o,
    input  logic [DATA_W-1:0]    pal_rdata_i,
    output logic [10:0]          active_cols_o,
    output logic [10:0]          active_rows_o,
    output logic [2:0]           bpp_mode_o,
    output logic                 bgr_o,
    output logic                 be_byte_o,
    output logic                 be_pix_o,
    output logic                 enable_o,
    output logic                 geometry_changed_o
);
    localparam int NUM_TIM = 4;
    localparam int PPL_W   = 6;
    localparam int LPP_W   = 10;
    localparam int PPL_LSB = 2;

    reg_sel_e            region;
    logic [2:0]          id_idx;
    logic                wr_hit, rd_hit, rd_bad;
    logic [DATA_W-1:0]   tim_q [NUM_TIM];
    logic [DATA_W-1:0]   upbase_q, lpbase_q, ctrl_q;
    logic [IRQ_W-1:0]    mask_q, raw_q, clr_bits;
    logic [DATA_W-1:0]   rd_mux;

    lcdreg_decode #(
        .EXTENDED  (EXTENDED),
        .ADDR_W    (ADDR_W),
        .PAL_IDX_W (PAL_IDX_W)
    ) u_decode (
        .addr_i    (bus_addr_i),
        .region_o  (region),
        .pal_idx_o (pal_index_o),
        .id_idx_o  (id_idx)
    );

    assign wr_hit = bus_sel_i &  bus_we_i;
    assign rd_hit = bus_sel_i & ~bus_we_i;

    // Palette forwarding
    assign pal_sel_o   = bus_sel_i && (region == SEL_PALETTE);
    assign pal_we_o    = bus_we_i;
    assign pal_wdata_o = bus_wdata_i;

    // Timing words, one register each
    for (genvar t = 0; t < NUM_TIM; t++) begin : g_tim
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                tim_q[t] <= '0;
            end else if (wr_hit && region == reg_sel_e'(t)) begin
                tim_q[t] <= bus_wdata_i;
            end
        end
    end

    assign clr_bits = (wr_hit && region == SEL_CLEAR) ? bus_wdata_i[IRQ_W-1:0] : '0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            upbase_q <= '0;
            lpbase_q <= '0;
            ctrl_q   <= '0;
            mask_q   <= '0;
            raw_q    <= '0;
        end else begin
            if (wr_hit && region == SEL_UPBASE) upbase_q <= bus_wdata_i;
            if (wr_hit && region == SEL_LPBASE) lpbase_q <= bus_wdata_i;
            if (wr_hit && region == SEL_CTRL)   ctrl_q   <= bus_wdata_i;
            if (wr_hit && region == SEL_MASK)   mask_q   <= bus_wdata_i[IRQ_W-1:0];
            raw_q <= (raw_q & ~clr_bits) | irq_evt_i;
        end
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        rd_bad = 1'b0;
        unique case (region)
            SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_TIM3:
                         rd_mux = tim_q[region[1:0]];
            SEL_UPBASE:  rd_mux = upbase_q;
            SEL_LPBASE:  rd_mux = lpbase_q;
            SEL_CTRL:    rd_mux = ctrl_q;
            SEL_MASK:    rd_mux = DATA_W'(mask_q);
            SEL_RAW:     rd_mux = DATA_W'(raw_q);
            SEL_MASKED:  rd_mux = DATA_W'(raw_q & mask_q);
            SEL_CURADDR: rd_mux = '0;
            SEL_PALETTE: rd_mux = pal_rdata_i;
            SEL_IDENT:   rd_mux = DATA_W'(ident_byte(EXTENDED, id_idx));
            default:     rd_bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bus_rdata_o <= '0;
            bus_err_o   <= 1'b0;
        end else begin
            bus_err_o <= rd_hit & rd_bad;
            if (rd_hit) bus_rdata_o <= rd_mux;
        end
    end

    lcdreg_panel #(
        .PPL_W (PPL_W),
        .LPP_W (LPP_W)
    ) u_panel (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ppl_i     (tim_q[0][PPL_LSB +: PPL_W]),
        .lpp_i     (tim_q[1][LPP_W-1:0]),
        .en_bit_i  (ctrl_q[CTL_EN]),
        .pwr_bit_i (ctrl_q[CTL_PWR]),
        .cols_o    (active_cols_o),
        .rows_o    (active_rows_o),
        .enable_o  (enable_o),
        .changed_o (geometry_changed_o)
    );

    assign bpp_mode_o = ctrl_q[CTL_BPP_LO +: 3];
    assign bgr_o      = ctrl_q[CTL_BGR];
    assign be_byte_o  = ctrl_q[CTL_BEBYTE];
    assign be_pix_o   = ctrl_q[CTL_BEPIX];

    // R11: error only after a read of an undecoded or write-only word
    a_r11_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_err_o |-> $past(rd_hit && (region == SEL_NONE || region == SEL_CLEAR)));

    // R11: undecoded writes touch nothing and raise no error
    a_r11_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit && region == SEL_NONE) |=>
            ($stable(ctrl_q) && $stable(mask_q) && $stable(tim_q[0]) &&
             $stable(tim_q[1]) && !bus_err_o));

    // R7: cleared bits are gone unless re-set by an event
    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit && region == SEL_CLEAR) |=>
            ((raw_q & $past(bus_wdata_i[IRQ_W-1:0] & ~irq_evt_i)) == '0));

    // R6: events always land in raw status
    a_r6_event_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_evt_i) |=> ((raw_q & $past(irq_evt_i)) == $past(irq_evt_i)));

    // R10: current-address words read zero without error
    a_r10_cur_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_hit && region == SEL_CURADDR) |=> (bus_rdata_o == '0 && !bus_err_o));

endmodule

// File: tb/lcdreg_top_test.sv
module lcdreg_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [4:0]  evt = '0;

    logic [31:0] o_rdata [2];
    logic        o_err   [2];
    logic        o_psel  [2];
    logic        o_pwe   [2];
    logic [6:0]  o_pidx  [2];
    logic [31:0] o_pwd   [2];
    logic [31:0] i_prd   [2];
    logic [10:0] o_cols  [2];
    logic [10:0] o_rows  [2];
    logic [2:0]  o_bpp   [2];
    logic        o_bgr [2], o_beb [2], o_bep [2], o_en [2], o_chg [2];

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdreg_top #(.EXTENDED(1'b0)) uut (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(o_rdata[0]),
        .bus_err_o(o_err[0]), .irq_evt_i(evt), .pal_sel_o(o_psel[0]),
        .pal_we_o(o_pwe[0]), .pal_index_o(o_pidx[0]), .pal_wdata_o(o_pwd[0]),
        .pal_rdata_i(i_prd[0]), .active_cols_o(o_cols[0]), .active_rows_o(o_rows[0]),
        .bpp_mode_o(o_bpp[0]), .bgr_o(o_bgr[0]), .be_byte_o(o_beb[0]),
        .be_pix_o(o_bep[0]), .enable_o(o_en[0]), .geometry_changed_o(o_chg[0]));

    lcdreg_top #(.EXTENDED(1'b1)) uut_ext (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(o_rdata[1]),
        .bus_err_o(o_err[1]), .irq_evt_i(evt), .pal_sel_o(o_psel[1]),
        .pal_we_o(o_pwe[1]), .pal_index_o(o_pidx[1]), .pal_wdata_o(o_pwd[1]),
        .pal_rdata_i(i_prd[1]), .active_cols_o(o_cols[1]), .active_rows_o(o_rows[1]),
        .bpp_mode_o(o_bpp[1]), .bgr_o(o_bgr[1]), .be_byte_o(o_beb[1]),
        .be_pix_o(o_bep[1]), .enable_o(o_en[1]), .geometry_changed_o(o_chg[1]));

    // External palette store stubs
    logic [31:0] pal_a [128];
    logic [31:0] pal_b [128];
    assign i_prd[0] = pal_a[o_pidx[0]];
    assign i_prd[1] = pal_b[o_pidx[1]];
    always @(posedge clk) begin
        if (o_psel[0] && o_pwe[0]) pal_a[o_pidx[0]] <= o_pwd[0];
        if (o_psel[1] && o_pwe[1]) pal_b[o_pidx[1]] <= o_pwd[1];
    end

    // Reference model state
    logic [31:0] m_tim  [2][4];
    logic [31:0] m_up [2], m_lp [2], m_ctrl [2];
    logic [4:0]  m_mask [2], m_raw [2];
    logic [31:0] m_rd [2];
    logic        m_err [2], m_chg [2];
    logic [31:0] m_pal [2][128];
    string       m_tag [2];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int region_of(input int v, input int a);
        int w;
        if (a >= 'h200 && a < 'h400) return 12;
        if (a >= 'hFE0) return 13;
        w = a / 4;
        if (w <= 5) return w;
        if (w == 6) return (v == 1) ? 7 : 6;
        if (w == 7) return (v == 1) ? 6 : 7;
        if (w <= 10) return w;
        if (w == 11 || w == 12) return 11;
        return 14;
    endfunction

    function automatic string tag_of(input int r);
        if (r <= 7) return "R5";
        if (r == 8 || r == 9) return "R6";
        if (r == 11) return "R10";
        if (r == 12) return "R9";
        if (r == 13) return "R8";
        return "R11";
    endfunction

    function automatic int id_val(input int v, input int i);
        int base [8] = '{'h10, 'h11, 'h04, 'h00, 'h0D, 'hF0, 'h05, 'hB1};
        if (v == 1 && i == 0) return 'h11;
        if (v == 1 && i == 2) return 'h24;
        return base[i];
    endfunction

    function automatic int exp_cols(input int v);
        return ((m_tim[v][0] & 'hFC) + 4) * 4;
    endfunction
    function automatic int exp_rows(input int v);
        return (m_tim[v][1] & 'h3FF) + 1;
    endfunction
    function automatic bit exp_en(input int v);
        return m_ctrl[v][0] & m_ctrl[v][11];
    endfunction

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            for (int t = 0; t < 4; t++) m_tim[v][t] = '0;
            m_up[v] = '0; m_lp[v] = '0; m_ctrl[v] = '0; m_mask[v] = '0;
            m_raw[v] = '0; m_rd[v] = '0; m_err[v] = 0; m_chg[v] = 0;
            m_tag[v] = "R1";
            for (int p = 0; p < 128; p++) m_pal[v][p] = '0;
        end
    endtask

    task automatic model_step();
        for (int v = 0; v < 2; v++) begin
            int r, c0, r0;
            bit e0;
            logic [4:0] clr;
            r = region_of(v, int'(addr));
            c0 = exp_cols(v); r0 = exp_rows(v); e0 = exp_en(v);
            clr = '0;
            m_err[v] = 0;
            if (sel && !we) begin
                m_tag[v] = tag_of(r);
                case (r)
                    0, 1, 2, 3: m_rd[v] = m_tim[v][r];
                    4:  m_rd[v] = m_up[v];
                    5:  m_rd[v] = m_lp[v];
                    6:  m_rd[v] = m_ctrl[v];
                    7:  m_rd[v] = 32'(m_mask[v]);
                    8:  m_rd[v] = 32'(m_raw[v]);
                    9:  m_rd[v] = 32'(m_raw[v] & m_mask[v]);
                    11: m_rd[v] = '0;
                    12: m_rd[v] = m_pal[v][(int'(addr) - 'h200) / 4];
                    13: m_rd[v] = 32'(id_val(v, (int'(addr) - 'hFE0) / 4));
                    default: begin m_rd[v] = '0; m_err[v] = 1; end
                endcase
            end
            if (sel && we) begin
                case (r)
                    0, 1, 2, 3: m_tim[v][r] = wdata;
                    4:  m_up[v] = wdata;
                    5:  m_lp[v] = wdata;
                    6:  m_ctrl[v] = wdata;
                    7:  m_mask[v] = wdata[4:0];
                    10: clr = wdata[4:0];
                    12: m_pal[v][(int'(addr) - 'h200) / 4] = wdata;
                    default: ;
                endcase
            end
            m_raw[v] = (m_raw[v] & ~clr) | evt;
            m_chg[v] = (exp_cols(v) != c0) || (exp_rows(v) != r0) || (exp_en(v) != e0);
        end
    endtask

    task automatic compare_all();
        for (int v = 0; v < 2; v++) begin
            chk(o_rdata[v] == m_rd[v], $sformatf("%s rdata v%0d", m_tag[v], v), o_rdata[v], m_rd[v]);
            chk(o_err[v] == m_err[v], $sformatf("R11 err v%0d", v), o_err[v], m_err[v]);
            chk(int'(o_cols[v]) == exp_cols(v), "R2 cols", o_cols[v], exp_cols(v));
            chk(int'(o_rows[v]) == exp_rows(v), "R3 rows", o_rows[v], exp_rows(v));
            chk(o_en[v] == exp_en(v), "R4 enable", o_en[v], exp_en(v));
            chk(o_bpp[v] == m_ctrl[v][3:1], "R4 bpp", o_bpp[v], m_ctrl[v][3:1]);
            chk({o_bgr[v], o_beb[v], o_bep[v]} == {m_ctrl[v][8], m_ctrl[v][9], m_ctrl[v][10]},
                "R4 order flags", {o_bgr[v], o_beb[v], o_bep[v]},
                {m_ctrl[v][8], m_ctrl[v][9], m_ctrl[v][10]});
            chk(o_chg[v] == m_chg[v], "R12 geometry_changed", o_chg[v], m_chg[v]);
        end
    endtask

    // One bus cycle: combinational palette check, edge, model, compare
    task automatic tick();
        #1;
        for (int v = 0; v < 2; v++) begin
            bit exp_sel;
            exp_sel = sel && (region_of(v, int'(addr)) == 12);
            chk(o_psel[v] == exp_sel, "R9 pal_sel", o_psel[v], exp_sel);
            if (exp_sel) begin
                chk(o_pwe[v] == we, "R9 pal_we", o_pwe[v], we);
                chk(int'(o_pidx[v]) == (int'(addr) - 'h200) / 4, "R9 pal_index",
                    o_pidx[v], (int'(addr) - 'h200) / 4);
                chk(o_pwd[v] == wdata, "R9 pal_wdata", o_pwd[v], wdata);
            end
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        sel = 1; we = 1; addr = 12'(a); wdata = d; tick();
        sel = 0; we = 0;
    endtask
    task automatic rd(input int a);
        sel = 1; we = 0; addr = 12'(a); wdata = '0; tick();
        sel = 0;
    endtask
    task automatic idle();
        sel = 0; we = 0; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int v = 0; v < 2; v++) begin
            chk(o_cols[v] == 11'd16, "R1 cols", o_cols[v], 16);
            chk(o_rows[v] == 11'd1, "R1 rows", o_rows[v], 1);
            chk(o_en[v] == 0 && o_chg[v] == 0 && o_err[v] == 0, "R1 flags",
                {o_en[v], o_chg[v], o_err[v]}, 0);
            chk(o_rdata[v] == '0, "R1 rdata", o_rdata[v], 0);
        end
        idle();
        rd('h18); rd('h20);
        // R2 / R3 geometry and R12 pulses
        wr('h00, 32'h0000_00FC); idle();
        wr('h00, 32'h0000_0013); rd('h00);
        wr('h00, 32'hFFFF_FF13);               // same decoded cols: no pulse
        wr('h04, 32'h0000_03FF); wr('h04, 32'h0000_0400); wr('h04, 32'h8000_0123); rd('h04);
        // R5 other words
        wr('h08, 32'hDEAD_BEEF); wr('h0C, 32'h1234_5678);
        wr('h10, 32'hA000_0000); wr('h14, 32'hA004_B000);
        rd('h08); rd('h0C); rd('h10); rd('h14); idle();
        // R4 / R5 variant offset swap
        wr('h1C, 32'h0000_000C); wr('h18, 32'h0000_000F);
        rd('h18); rd('h1C);
        // R6 events and masked status
        evt = 5'b10110; idle(); evt = '0;
        rd('h20); rd('h24);
        // R7 clear with simultaneous event
        evt = 5'b00001; wr('h28, 32'h0000_0006); evt = '0;
        rd('h20);
        chk(o_rdata[0] == 32'h11, "R7 clear raw", o_rdata[0], 32'h11);
        wr('h28, 32'hFFFF_FFFF); rd('h20);
        // R4 enable / R12 pulse on enable change
        wr('h18, 32'h0000_0801); idle();
        wr('h18, 32'h0000_0801);
        wr('h1C, 32'h0000_0F01); rd('h1C);
        wr('h18, 32'h0000_0800); idle();
        // R8 identification bytes
        for (int i = 0; i < 8; i++) rd('hFE0 + 4 * i);
        // R9 palette round trip
        wr('h200, 32'h0012_3456); wr('h3FC, 32'hCAFE_F00D); wr('h2A8, 32'h7FFF_0001);
        rd('h200); rd('h3FC); rd('h2A8);
        // R10 current-address words
        wr('h2C, 32'hFFFF_FFFF); rd('h2C); rd('h30);
        // R11 undecoded accesses
        rd('h34); idle(); rd('h400); rd('hFDC); rd('h28); rd('h1FC);
        wr('h100, 32'hFFFF_FFFF); wr('h34, 32'hFFFF_FFFF);
        rd('h18); rd('h1C); rd('h00); rd('h04);
        repeat (3) idle();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule